// File: doc/BRIEF.md
# Synchronous Burst Read Controller with WAIT Handshake

This block is the read side of a memory interface whose address and data share one bus. A bus master selects the device with an active-low chip enable and strobes an address with an active-low address-valid input. The block captures the address on that clock edge. In synchronous mode it then counts a programmable first-access latency and presents consecutive words from a small internal word array, one per clock. In asynchronous mode it returns the single word at the captured address.

A WAIT output tells the master when the bus carries valid data. Its active level is programmable. It is driven only while the chip is selected. It changes only on clock edges inside an active read cycle. A flow-through option shortens the first access by one clock.

A six-bit configuration word holds the mode, the WAIT polarity, the flow-through enable and the latency. It is written through a load strobe and returns to its defaults on reset.

Top module: `burst_wait_ctrl`

## Requirements
- R1: After reset the configuration is asynchronous mode, WAIT active-high, latency 4 and flow-through off. The reset value of cfgData[15:10] is 6'b101001.
- R2: When cfgData bit 15 is 1 (asynchronous), the word at the captured address is on the bus after the capture edge. It stays there with no address increment until the next capture.
- R3: Bit 10 sets the WAIT polarity. When it is 1, the asserted level of waitOut is 1. When it is 0, the asserted level is 0. The deasserted level is always the opposite of the asserted level.
- R4: The internal WAIT state changes only at clock edges where ceN=0 and oeN=0. At any other edge, waitOut keeps its level.
- R5: In synchronous mode (bit 15 = 0) with weN=1, WAIT is deasserted exactly in the cycles in which the bus carries a valid word. In all other cycles it is asserted.
- R6: In asynchronous mode, or when weN=0, each updating edge sets WAIT to its deasserted level.
- R7: waitOe equals the inverse of ceN: WAIT is high-impedance while ceN=1 and driven while ceN=0.
- R8: The address is captured at a rising edge with ceN=0 and advN=0. In synchronous mode the first word is valid after the L-th edge that follows the capture edge. L is the latency field, bits 13:11.
- R9: When bit 14 (flow-through) is 1, the first word and the WAIT deassertion come one edge earlier, after edge L-1.
- R10: After the first word, the burst address increments by one on every edge. The word at address A is ((A mod 16)+1)*37, XORed with A>>4 and truncated to 16 bits. adqOe is 1 only when ceN=0, oeN=0, rstN=1 and a word is valid. ceN=1 ends the burst.
- R11: A latency field value of 0 or 1 is treated as 4. Values 2 to 7 are used as they are.
- R12: rstN=0 asynchronously clears the burst state and the WAIT state. It also restores the configuration and sets adqOe to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write indication |
| advN | input | 1 | Active-low address-valid strobe |
| cfgWe | input | 1 | Loads the configuration word at the clock edge |
| cfgData | input | 6 (bits 15:10) | Configuration: 15 async, 14 flow-through, 13:11 latency, 10 WAIT polarity |
| adqIn | input | 16 | Address half of the shared bus |
| adqOut | output | 16 | Data half of the shared bus |
| adqOe | output | 1 | Drive enable for adqOut |
| waitOut | output | 1 | WAIT level |
| waitOe | output | 1 | Drive enable for waitOut |

## Verification
Bursts are issued at every legal latency, at the illegal latency codes, and with flow-through on and off. The measured first-word edge separates a correct latency count from an off-by-one or a flow-through applied in the wrong direction. A burst that starts near the end of the array exposes a wrong increment or wrap. Runs with the polarity cleared, with weN low, and with oeN raised while data becomes valid separate a polarity error from a gating error. A reset in mid-burst, followed by a default-mode read, shows whether both the configuration and the burst state were cleared.

// File: rtl/burst_wait_pkg.sv
package burst_wait_pkg;
  localparam int CFG_HI = 15;
  localparam int CFG_LO = 10;
  localparam int CFG_ASYNC_BIT = 15;
  localparam int CFG_FT_BIT = 14;
  localparam int CFG_LAT_HI = 13;
  localparam int CFG_LAT_LO = 11;
  localparam int CFG_WPOL_BIT = 10;
  localparam int LAT_W = CFG_LAT_HI - CFG_LAT_LO + 1;
  localparam logic [CFG_HI:CFG_LO] CFG_DEFAULT = 6'b101001;
  localparam logic [LAT_W-1:0] LAT_DEFAULT = 3'd4;
  localparam logic [LAT_W-1:0] LAT_MIN = 3'd2;

  typedef struct packed {
    logic capture;
    logic asyncFetch;
    logic step;
  } strobeT;
endpackage

// File: rtl/burst_wait_datapath.sv
module burst_wait_datapath
  import burst_wait_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int WORD_SEED = 37
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strobe,
  input  logic [DW-1:0] adqIn,
  output logic [DW-1:0] dataQ
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rom [DEPTH];
  logic [DW-1:0] addrQ;

  for (genvar g = 0; g < DEPTH; g++) begin : gRom
    assign rom[g] = DW'((g + 1) * WORD_SEED);
  end

  function automatic logic [DW-1:0] wordAt(input logic [DW-1:0] a);
    return rom[a[AW-1:0]] ^ (a >> AW);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= adqIn;
      if (strobe.asyncFetch) dataQ <= wordAt(adqIn);
    end else if (strobe.step) begin
      dataQ <= wordAt(addrQ);
      addrQ <= addrQ + 1'b1;
    end
  end

  // R10: each burst step moves to the next address
  p_step_incr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.capture) |=> (addrQ == DW'($past(addrQ) + 1'b1)));
endmodule

// File: rtl/burst_wait_control.sv
module burst_wait_control
  import burst_wait_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  oeN,
  input  logic                  weN,
  input  logic                  advN,
  input  logic                  cfgWe,
  input  logic [CFG_HI:CFG_LO]  cfgData,
  output strobeT                strobe,
  output logic                  validQ,
  output logic                  waitAsserted,
  output logic                  waitHigh
);
  logic [CFG_HI:CFG_LO] cfgQ;
  logic [LAT_W-1:0] cntQ, cntNext, latRaw, latEff, delay;
  logic asyncMode, flowThru, validNext;

  assign asyncMode = cfgQ[CFG_ASYNC_BIT];
  assign flowThru  = cfgQ[CFG_FT_BIT];
  assign waitHigh  = cfgQ[CFG_WPOL_BIT];
  assign latRaw    = cfgQ[CFG_LAT_HI:CFG_LAT_LO];
  assign latEff    = (latRaw < LAT_MIN) ? LAT_DEFAULT : latRaw;
  assign delay     = latEff - LAT_W'(flowThru);

  always_comb begin
    strobe.capture    = !ceN && !advN;
    strobe.asyncFetch = strobe.capture && asyncMode;
    strobe.step       = !ceN && advN && !asyncMode && ((cntQ == 1) || validQ);
    validNext = validQ;
    cntNext   = cntQ;
    if (strobe.capture) begin
      validNext = asyncMode;
      cntNext   = asyncMode ? '0 : delay;
    end else if (ceN) begin
      validNext = 1'b0;
      cntNext   = '0;
    end else if (strobe.step) begin
      validNext = 1'b1;
      cntNext   = '0;
    end else if (cntQ > 1) begin
      cntNext = cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ         <= CFG_DEFAULT;
      cntQ         <= '0;
      validQ       <= 1'b0;
      waitAsserted <= 1'b0;
    end else begin
      if (cfgWe) cfgQ <= cfgData;
      cntQ   <= cntNext;
      validQ <= validNext;
      if (!ceN && !oeN) waitAsserted <= !asyncMode && weN && !validNext;
    end
  end

  // R4: no WAIT change outside an active read cycle
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |=> $stable(waitAsserted));
  // R5: synchronous WAIT is the inverse of data valid
  p_sync_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !asyncMode && weN) |=> (waitAsserted != validQ));
  // R6: asynchronous reads and writes leave WAIT deasserted
  p_async_nowait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && (asyncMode || !weN)) |=> !waitAsserted);
  // R8: the last latency count yields valid data
  p_first_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == 1 && !ceN && advN) |=> validQ);
endmodule

// File: rtl/burst_wait_ctrl.sv
module burst_wait_ctrl
  import burst_wait_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic                 advN,
  input  logic                 cfgWe,
  input  logic [CFG_HI:CFG_LO] cfgData,
  input  logic [DW-1:0]        adqIn,
  output logic [DW-1:0]        adqOut,
  output logic                 adqOe,
  output logic                 waitOut,
  output logic                 waitOe
);
  strobeT strobe;
  logic validQ, waitAsserted, waitHigh;

  burst_wait_control uControl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
    .cfgWe(cfgWe), .cfgData(cfgData), .strobe(strobe), .validQ(validQ),
    .waitAsserted(waitAsserted), .waitHigh(waitHigh)
  );

  burst_wait_datapath #(.DW(DW), .AW(AW)) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adqIn(adqIn), .dataQ(adqOut)
  );

  assign adqOe   = rstN && !ceN && !oeN && validQ;
  assign waitOe  = !ceN;
  assign waitOut = waitHigh ? waitAsserted : !waitAsserted;
endmodule

// File: tb/burst_wait_ctrl_test.sv
module burst_wait_ctrl_test;
  logic clk = 0, rstN = 0, ceN = 1, oeN = 1, weN = 1, advN = 1, cfgWe = 0;
  logic [15:10] cfgData = '0;
  logic [15:0] adqIn = '0;
  logic [15:0] adqOut;
  logic adqOe, waitOut, waitOe;
  int nChecks = 0, nFails = 0;
  bit running = 0;

  logic [15:10] mCfg;
  int mCnt, mAddr, mData;
  bit mValid, mWait;

  burst_wait_ctrl uut (.clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .advN(advN), .cfgWe(cfgWe), .cfgData(cfgData), .adqIn(adqIn),
    .adqOut(adqOut), .adqOe(adqOe), .waitOut(waitOut), .waitOe(waitOe));

  always #4 clk = ~clk;

  function automatic int wordOf(int a);
    return ((((a % 16) + 1) * 37) ^ (a >> 4)) & 16'hFFFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCfg = 6'b101001; mCnt = 0; mValid = 0; mAddr = 0; mData = 0; mWait = 0;
    end else begin
      int lat, d;
      bit asy;
      asy = mCfg[15];
      lat = int'(mCfg[13:11]);
      if (lat < 2) lat = 4;
      d = lat - int'(mCfg[14]);
      if (!ceN && !advN) begin
        mAddr = int'(adqIn);
        if (asy) begin mData = wordOf(mAddr); mValid = 1; mCnt = 0; end
        else begin mValid = 0; mCnt = d; end
      end else if (ceN) begin
        mValid = 0; mCnt = 0;
      end else if (!asy && (mCnt == 1 || mValid)) begin
        mData = wordOf(mAddr); mAddr = (mAddr + 1) & 16'hFFFF; mValid = 1; mCnt = 0;
      end else if (mCnt > 1) begin
        mCnt = mCnt - 1;
      end
      if (!ceN && !oeN) mWait = !asy && weN && !mValid;
      if (cfgWe) mCfg = cfgData;
    end
  end

  always @(posedge clk) begin
    #3;
    if (running) begin
      chk("R7 waitOe model", int'(waitOe), int'(!ceN));
      if (!ceN) chk("R5 waitOut model", int'(waitOut), mWait ? int'(mCfg[10]) : int'(!mCfg[10]));
      chk("R8 adqOe model", int'(adqOe), int'(rstN && !ceN && !oeN && mValid));
      if (adqOe) chk("R10 adqOut model", int'(adqOut), mData);
    end
  end

  task automatic idle(int n);
    @(negedge clk); ceN = 1; oeN = 1; advN = 1; weN = 1; cfgWe = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(logic [15:10] v);
    @(negedge clk); cfgWe = 1; cfgData = v;
    @(negedge clk); cfgWe = 0;
  endtask

  // capture at edge 0, report index of first edge after which data is valid
  task automatic burst(int addr, int n, bit we, output int first);
    first = -1;
    @(negedge clk); ceN = 0; oeN = 0; advN = 0; weN = we; adqIn = 16'(addr);
    @(negedge clk); advN = 1;
    for (int k = 1; k <= n; k++) begin
      if (k > 1) @(posedge clk);
      else @(posedge clk);
      #3;
      if (adqOe && first < 0) first = k;
    end
    idle(1);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    rstN = 1; running = 1;
    @(posedge clk); #3;
    chk("R1 adqOe after reset", int'(adqOe), 0);
    chk("R7 waitOe deselected", int'(waitOe), 0);

    // R1/R2: default asynchronous single-word read
    @(negedge clk); ceN = 0; oeN = 0; advN = 0; adqIn = 16'd5;
    @(posedge clk); #3;
    chk("R2 async data valid", int'(adqOe), 1);
    chk("R2 async word", int'(adqOut), wordOf(5));
    chk("R6 async wait deasserted (R1 active-high)", int'(waitOut), 0);
    chk("R7 waitOe selected", int'(waitOe), 1);
    @(negedge clk); advN = 1;
    repeat (3) @(posedge clk); #3;
    chk("R2 no increment", int'(adqOut), wordOf(5));
    idle(2);

    // R8: sync, latency 4, WAIT high
    setCfg(6'b001001);
    burst(3, 10, 1, first); chk("R8 latency 4", first, 4);
    burst(14, 10, 1, first); chk("R10 wrap burst latency", first, 4);
    setCfg(6'b000101); burst(0, 10, 1, first); chk("R8 latency 2", first, 2);
    setCfg(6'b001111); burst(7, 12, 1, first); chk("R8 latency 7", first, 7);
    setCfg(6'b011001); burst(1, 10, 1, first); chk("R9 flow-through 4", first, 3);
    setCfg(6'b010101); burst(1, 10, 1, first); chk("R9 flow-through 2", first, 1);
    setCfg(6'b000011); burst(2, 10, 1, first); chk("R11 latency code 1", first, 4);
    setCfg(6'b000001); burst(2, 10, 1, first); chk("R11 latency code 0", first, 4);

    // R3: polarity low
    setCfg(6'b001000);
    @(negedge clk); ceN = 0; oeN = 0; advN = 0; adqIn = 16'd9;
    @(negedge clk); advN = 1;
    @(posedge clk); #3; chk("R3 asserted low", int'(waitOut), 0);
    repeat (3) @(posedge clk); #3;
    chk("R3 deasserted high", int'(waitOut), 1);
    chk("R10 first word", int'(adqOut), wordOf(9));
    @(posedge clk); #3; chk("R10 second word", int'(adqOut), wordOf(10));
    idle(1);

    // R4: OE high freezes WAIT while data becomes valid
    setCfg(6'b001001);
    @(negedge clk); ceN = 0; oeN = 0; advN = 0; adqIn = 16'd2;
    @(negedge clk); advN = 1;
    @(negedge clk); oeN = 1;
    repeat (5) @(posedge clk); #3;
    chk("R4 wait frozen", int'(waitOut), 1);
    chk("R10 bus off with oeN high", int'(adqOe), 0);
    @(negedge clk); oeN = 0;
    @(posedge clk); #3;
    chk("R4 wait updates", int'(waitOut), 0);
    idle(1);

    // R6: write cycle keeps WAIT deasserted
    @(negedge clk); ceN = 0; oeN = 0; advN = 0; weN = 0; adqIn = 16'd4;
    @(negedge clk); advN = 1;
    @(posedge clk); #3; chk("R6 write wait deasserted", int'(waitOut), 0);
    idle(1);

    // R12: reset mid-burst
    @(negedge clk); ceN = 0; oeN = 0; advN = 0; adqIn = 16'd6;
    @(negedge clk); advN = 1;
    repeat (6) @(posedge clk);
    @(negedge clk); rstN = 0; #1;
    chk("R12 bus tri-stated in reset", int'(adqOe), 0);
    @(negedge clk); rstN = 1; ceN = 1;
    @(negedge clk); ceN = 0; oeN = 0; advN = 0; adqIn = 16'd11;
    @(posedge clk); #3;
    chk("R12 config back to async", int'(adqOe), 1);
    chk("R12 async word after reset", int'(adqOut), wordOf(11));
    idle(2);

    running = 0;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule